// File: doc/BRIEF.md
# Single-Mode DMA Channel Transfer Engine

This block is the per-channel datapath and sequencer of a DMA controller. It holds the working address and remaining-count registers and their base copies. It raises a bus hold request when an unmasked device asks for service, and it waits for the bus grant. It then performs exactly one transfer cycle: it drives the physical address, the device acknowledge and a matching pair of memory and I/O strobes. After that cycle it releases the bus. Host-side register decoding and arbitration between channels sit outside this block.

The count is kept as "transfers minus one". The channel finishes when the count steps below zero and wraps to all ones. At that point it either reloads its working registers from the base copies, when autoinit is on, or masks itself. The upper page bits never take part in stepping, so one run stays inside one 64K byte window or one 128K word window. A word channel presents the 16-bit register shifted left by one and ignores the lowest page bit. In cascade mode the channel does no sequencing. It only forwards the request to the hold request and the grant back to the acknowledge.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is masked (`mask_o`=1), and `hrq_o`, `dack_o`, `tc_o`, all four strobes and `addr_o` are 0.
- R2: While `mask_o` is 1, `dreq_i` has no effect: `hrq_o` and `dack_o` stay 0. A `load_i` pulse clears the mask and copies `base_addr_i`/`base_cnt_i` into both the base and the working registers.
- R3: When the channel is unmasked and not in cascade, `dreq_i` raises `hrq_o` one cycle later. The first cycle in which `hlda_i` is seen high is followed by exactly one cycle with `dack_o`=1. After that cycle `hrq_o` and `dack_o` are low for at least one cycle.
- R4: On a byte channel (`word_i`=0) the address in the acknowledge cycle is {page[7:0], addr[15:0]}.
- R5: On a word channel (`word_i`=1) the address in the acknowledge cycle is {page[7:1], addr[15:0], 1'b0}. Page bit 0 has no effect.
- R6: With mode bit 5 clear, the working address increments by one after each transfer and wraps from 0xFFFF to 0x0000 with no carry into the page.
- R7: With mode bit 5 set, the working address decrements by one after each transfer and wraps from 0x0000 to 0xFFFF with no borrow from the page.
- R8: A loaded count of N gives N+1 transfers. `tc_o` is high only in the acknowledge cycle of the transfer that starts with a count of 0. Without autoinit the count then reads 0xFFFF.
- R9: Mode bits [3:2]=01 (for example 0x44) assert `io_rd_o` and `mem_wr_o`. Bits [3:2]=10 (for example 0x48) assert `mem_rd_o` and `io_wr_o`. Strobes are asserted only in the acknowledge cycle.
- R10: With mode bit 4 clear, terminal count sets `mask_o`, and later requests are ignored.
- R11: With mode bit 4 set (for example 0x54), terminal count reloads the working address and count from the base copies and leaves the mask clear.
- R12: With mode bits [7:6]=11 (0xC0), `hrq_o` follows `dreq_i` and `dack_o` follows `hlda_i` in the same cycle while unmasked. `addr_o`, `tc_o` and all strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load base and working registers, clear mask |
| mode_i | input | 8 | Channel mode byte |
| base_addr_i | input | 16 | Start address register value |
| base_cnt_i | input | 16 | Transfer count minus one |
| page_i | input | 8 | Page value for the upper address bits |
| word_i | input | 1 | 1 selects word channel mapping |
| dreq_i | input | 1 | Device request |
| hlda_i | input | 1 | Bus hold acknowledge (grant) |
| hrq_o | output | 1 | Bus hold request |
| dack_o | output | 1 | Device acknowledge |
| addr_o | output | 24 | Physical address during the transfer cycle |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| tc_o | output | 1 | Terminal count pulse |
| mask_o | output | 1 | Channel mask state |
| cur_cnt_o | output | 16 | Working count readback |

## Verification
Some rules are checked on every cycle. The acknowledge lasts a single cycle and follows a sampled grant. Strobes and terminal count appear only inside that cycle. A masked channel never holds the bus. After terminal count the channel masks itself or stays unmasked, as autoinit selects. Cascade mode produces no address. The exact address value is left to the bench scenarios: byte and word mapping, page bit 0, 16-bit wrap in both directions, the N+1 transfer count and the reloaded values after autoinit. The bench compares each of these with a model of the working registers.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } st_e;

  typedef enum logic [1:0] {
    XT_NONE     = 2'b00,
    XT_TO_MEM   = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_BAD      = 2'b11
  } xtype_e;

  typedef struct packed {
    logic   cascade;
    logic   autoinit;
    logic   decr;
    xtype_e xtype;
  } mode_t;

  function automatic mode_t decode_mode(input logic [7:0] m);
    mode_t r;
    r.cascade  = (m[7:6] == 2'b11);
    r.autoinit = m[4];
    r.decr     = m[5];
    r.xtype    = xtype_e'(m[3:2]);
    return r;
  endfunction

endpackage

// File: rtl/dma_mode_dec.sv
module dma_mode_dec
  import dma_eng_pkg::*;
(
  input  logic [7:0] mode_i,
  output mode_t      mode_o
);
  always_comb mode_o = decode_mode(mode_i);
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0] base_cnt_i,
  input  logic             step_i,
  input  logic             decr_i,
  input  logic             autoinit_i,
  output logic [CNT_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0] cur_cnt_o,
  output logic             cnt_zero_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;

  assign cnt_zero_o = (cur_cnt_q == '0);
  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else if (load_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
      cur_addr_q  <= base_addr_i;
      cur_cnt_q   <= base_cnt_i;
    end else if (step_i) begin
      if (cnt_zero_o && autoinit_i) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else begin
        // 16-bit wrap only; page is never touched
        cur_addr_q <= decr_i ? cur_addr_q - ONE : cur_addr_q + ONE;
        cur_cnt_q  <= cur_cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = CNT_W + PAGE_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CNT_W-1:0]  cur_addr_i,
  input  logic              word_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] byte_addr, word_addr;

  assign byte_addr = {page_i, cur_addr_i};
  // word channels: low page bit dropped, register shifted by one
  assign word_addr = {page_i[PAGE_W-1:1], cur_addr_i, 1'b0};
  assign addr_o    = word_i ? word_addr : byte_addr;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = CNT_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        mode_i,
  input  logic [CNT_W-1:0]  base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              word_i,
  input  logic              dreq_i,
  input  logic              hlda_i,
  output logic              hrq_o,
  output logic              dack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic              tc_o,
  output logic              mask_o,
  output logic [CNT_W-1:0]  cur_cnt_o
);
  mode_t             md;
  st_e               st_q, st_d;
  logic              mask_q;
  logic              xfer;
  logic              cnt_zero;
  logic [CNT_W-1:0]  cur_addr;
  logic [ADDR_W-1:0] map_addr;

  dma_mode_dec u_dec (
    .mode_i (mode_i),
    .mode_o (md)
  );

  dma_xfer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .base_addr_i (base_addr_i),
    .base_cnt_i  (base_cnt_i),
    .step_i      (xfer),
    .decr_i      (md.decr),
    .autoinit_i  (md.autoinit),
    .cur_addr_o  (cur_addr),
    .cur_cnt_o   (cur_cnt_o),
    .cnt_zero_o  (cnt_zero)
  );

  dma_addr_map #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_map (
    .page_i     (page_i),
    .cur_addr_i (cur_addr),
    .word_i     (word_i),
    .addr_o     (map_addr)
  );

  assign xfer = (st_q == ST_XFER);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (!mask_q && dreq_i && !md.cascade) st_d = ST_REQ;
      ST_REQ:  if (hlda_i) st_d = ST_XFER;
               else if (!dreq_i) st_d = ST_IDLE;
      ST_XFER: st_d = ST_IDLE;  // single mode: release bus after one cycle
      default: st_d = ST_IDLE;
    endcase
    if (load_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (load_i) mask_q <= 1'b0;
      else if (xfer && cnt_zero && !md.autoinit) mask_q <= 1'b1;
    end
  end

  always_comb begin
    if (md.cascade) begin
      hrq_o  = dreq_i && !mask_q;
      dack_o = hlda_i && !mask_q;
    end else begin
      hrq_o  = (st_q == ST_REQ) || xfer;
      dack_o = xfer;
    end
  end

  assign addr_o   = xfer ? map_addr : '0;
  assign io_rd_o  = xfer && (md.xtype == XT_TO_MEM);
  assign mem_wr_o = xfer && (md.xtype == XT_TO_MEM);
  assign mem_rd_o = xfer && (md.xtype == XT_FROM_MEM);
  assign io_wr_o  = xfer && (md.xtype == XT_FROM_MEM);
  assign tc_o     = xfer && cnt_zero;
  assign mask_o   = mask_q;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [7:0]        mode_i,
  input logic              hlda_i,
  input logic              hrq_o,
  input logic              dack_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              io_rd_o,
  input logic              io_wr_o,
  input logic              tc_o,
  input logic              mask_o,
  input logic [CNT_W-1:0]  cur_cnt_o
);
  logic casc;
  assign casc = (mode_i[7:6] == 2'b11);

  a_r3_single_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && !casc) |=> !dack_o);

  a_r3_grant_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && !casc) |-> $past(hlda_i));

  a_r9_strobe_in_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |-> dack_o);

  a_r9_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && !(io_rd_o && io_wr_o));

  a_r8_tc_in_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> dack_o);

  a_r8_tc_wraps_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !mode_i[4] && !load_i) |=> (cur_cnt_o == {CNT_W{1'b1}}));

  a_r10_mask_on_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !mode_i[4] && !load_i) |=> mask_o);

  a_r11_auto_keeps_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && mode_i[4] && !mask_o) |=> !mask_o);

  a_r2_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o |-> (!hrq_o && !dack_o));

  a_r12_casc_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc |-> (addr_o == '0 && !tc_o && !mem_rd_o && !io_wr_o));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .mode_i    (mode_i),
  .hlda_i    (hlda_i),
  .hrq_o     (hrq_o),
  .dack_o    (dack_o),
  .addr_o    (addr_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .io_rd_o   (io_rd_o),
  .io_wr_o   (io_wr_o),
  .tc_o      (tc_o),
  .mask_o    (mask_o),
  .cur_cnt_o (cur_cnt_o)
);

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [7:0]  mode = 8'h44;
  logic [15:0] base_addr = '0, base_cnt = '0;
  logic [7:0]  page = '0;
  logic        word = 1'b0;
  logic        dreq = 1'b0, hlda = 1'b0;
  logic        hrq, dack, mem_rd, mem_wr, io_rd, io_wr, tc, mask;
  logic [23:0] addr;
  logic [15:0] cur_cnt;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // model of working registers
  logic [15:0] m_addr, m_cnt, m_baddr, m_bcnt;
  logic        m_mask;

  always #2 clk = ~clk;

  dma_chan_engine u_dma_chan_engine (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .mode_i(mode),
    .base_addr_i(base_addr), .base_cnt_i(base_cnt), .page_i(page),
    .word_i(word), .dreq_i(dreq), .hlda_i(hlda), .hrq_o(hrq),
    .dack_o(dack), .addr_o(addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .tc_o(tc), .mask_o(mask),
    .cur_cnt_o(cur_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr(input logic [7:0] pg, input logic w, input logic [15:0] a);
    return w ? {pg[7:1], a, 1'b0} : {pg, a};
  endfunction

  function automatic logic [3:0] exp_strb(input logic [7:0] m);
    // {mem_rd, mem_wr, io_rd, io_wr}
    case (m[3:2])
      2'b01:   return 4'b0110;
      2'b10:   return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic do_load(input logic [7:0] md, input logic [7:0] pg, input logic w,
                         input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    mode = md; page = pg; word = w; base_addr = a; base_cnt = c; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    m_addr = a; m_cnt = c; m_baddr = a; m_bcnt = c; m_mask = 1'b0;
  endtask

  task automatic do_xfer();
    logic etc;
    @(negedge clk);
    dreq = 1'b1;
    @(negedge clk);
    chk(hrq && !dack, "R3 hrq after dreq", {hrq, dack}, 2'b10);
    hlda = 1'b1;
    @(negedge clk);
    etc = (m_cnt == 16'h0);
    chk(dack && hrq, "R3 dack in grant cycle", {hrq, dack}, 2'b11);
    chk(addr == exp_addr(page, word, m_addr), word ? "R5 word addr" : "R4 byte addr",
        addr, exp_addr(page, word, m_addr));
    chk({mem_rd, mem_wr, io_rd, io_wr} == exp_strb(mode), "R9 strobes",
        {mem_rd, mem_wr, io_rd, io_wr}, exp_strb(mode));
    chk(tc == etc, "R8 tc", tc, etc);
    dreq = 1'b0; hlda = 1'b0;
    @(negedge clk);
    chk(!dack && !hrq, "R3 bus released", {hrq, dack}, 2'b00);
    if (etc && mode[4]) begin
      m_addr = m_baddr; m_cnt = m_bcnt;
    end else begin
      m_addr = mode[5] ? m_addr - 16'd1 : m_addr + 16'd1;
      m_cnt  = m_cnt - 16'd1;
      if (etc) m_mask = 1'b1;
    end
    chk(cur_cnt == m_cnt, "R8 count", cur_cnt, m_cnt);
    chk(mask == m_mask, mode[4] ? "R11 mask" : "R10 mask", mask, m_mask);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #10;
    // R1 reset state
    @(negedge clk);
    chk(mask && !hrq && !dack && !tc && addr == 0 && !mem_rd && !mem_wr && !io_rd && !io_wr,
        "R1 reset", {mask, hrq, dack, tc}, 4'b1000);
    rst_n = 1'b1;
    // R2 masked channel ignores request
    @(negedge clk); dreq = 1'b1; hlda = 1'b1;
    repeat (3) @(negedge clk);
    chk(!hrq && !dack, "R2 masked ignore", {hrq, dack}, 2'b00);
    dreq = 1'b0; hlda = 1'b0;

    // R6 increment wrap, byte, no autoinit (R8: cnt 2 -> 3 transfers)
    do_load(8'h44, 8'h12, 1'b0, 16'hFFFE, 16'd2);
    chk(!mask && cur_cnt == 16'd2, "R2 load unmasks", {mask, cur_cnt}, {1'b0, 16'd2});
    repeat (3) do_xfer();
    chk(m_addr == 16'h0001, "R6 model wrap", m_addr, 16'h0001);
    chk(cur_cnt == 16'hFFFF, "R8 count wraps", cur_cnt, 16'hFFFF);
    // R10 masked after terminal count
    @(negedge clk); dreq = 1'b1;
    repeat (3) @(negedge clk);
    chk(!hrq && mask, "R10 masked after tc", {hrq, mask}, 2'b01);
    dreq = 1'b0;

    // R7 decrement wrap on word channel, page bit 0 set (R5)
    do_load(8'h68, 8'h35, 1'b1, 16'h0001, 16'd2);
    repeat (3) do_xfer();

    // R11 autoinit reload, count 0 means one transfer per run
    do_load(8'h54, 8'hA0, 1'b0, 16'h1234, 16'd0);
    repeat (3) do_xfer();
    chk(!mask && cur_cnt == 16'd0, "R11 reload", {mask, cur_cnt}, 17'd0);

    // R12 cascade pass-through
    do_load(8'hC0, 8'h55, 1'b0, 16'h4444, 16'd7);
    @(negedge clk); dreq = 1'b1; #1;
    chk(hrq && !dack, "R12 hrq follows dreq", {hrq, dack}, 2'b10);
    hlda = 1'b1; #1;
    chk(dack && addr == 0 && !tc && !mem_rd && !mem_wr && !io_rd && !io_wr,
        "R12 dack follows hlda", {dack, addr}, {1'b1, 24'h0});
    dreq = 1'b0; #1;
    chk(!hrq && dack, "R12 hrq drops", {hrq, dack}, 2'b01);
    hlda = 1'b0; #1;
    chk(!dack, "R12 dack drops", dack, 0);
    chk(cur_cnt == 16'd7, "R12 no stepping", cur_cnt, 16'd7);

    // constrained random runs
    for (int it = 0; it < 24; it++) begin
      logic [7:0]  md;
      logic [15:0] a;
      logic [15:0] c;
      int n;
      md = 8'h40 | (($urandom % 2) ? 8'h04 : 8'h08)
                 | (($urandom % 2) ? 8'h20 : 8'h00)
                 | (($urandom % 2) ? 8'h10 : 8'h00);
      a  = ($urandom % 2) ? 16'($urandom % 4) : 16'hFFFF - 16'($urandom % 4);
      c  = 16'($urandom % 5);
      do_load(md, 8'($urandom), 1'($urandom), a, c);
      n = int'(c) + 1 + (md[4] ? 2 : 0);
      for (int k = 0; k < n; k++) do_xfer();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule